// File: doc/BRIEF.md
# Network Controller Power-State Wake Manager

This block follows the device power state of a network controller attached to a PCI-style bus. From that state it decides which bus activity the controller may start or answer. Software requests a state from D0 (fully on) to D3 (deepest). In D0 the controller may master the bus and raise interrupts. In D1, D2 and D3 it may only answer configuration accesses. Enable bits for the active-low wake signal and for a link-down low-power sub-mode are held in registers that survive a bus reset.

The wake side runs from auxiliary power and has its own reset. The link-valid indication arrives asynchronously and passes through a synchroniser before edge detection. In any non-D0 state with wake enabled, a wake-packet match or a change of the synchronised link sets a pending wake status. That status pulls the wake output low until software clears it or disables wake. A bus reset, or loss of bus power-good, makes the block ignore every bus-side input. When the bus comes back, only the function state returns to D0. Wake enables and a pending wake are kept, so a system can sleep with the bus unpowered and still be woken.

Top module: `nic_pm_wake_mgr`

## Requirements
- R1: While `aux_rst_n` is low, the function state is D0, both enable registers and the pending wake status are 0, `pme_n` is 1, and `low_power` and `cfg_resp_ok` are 0.
- R2: While `bus_rst_n` is low or `pwr_good` is low, the inputs `req_dstate`, `pme_en`, `lp_en`, `cfg_strobe` and `pme_clr` have no effect, and `bus_master_ok`, `irq_ok` and `cfg_resp_ok` are 0 from the next cycle.
- R3: Bus reset or power loss never clears the wake enable, the low-power enable or the pending wake status. At the first clock edge with the bus active again, the state is set to D0 and `req_dstate` is ignored. From the next edge on, `req_dstate` is followed.
- R4: The state follows `req_dstate` at each clock edge while the bus is active (encoding 0=D0, 1=D1, 2=D2, 3=D3). `bus_master_ok` and `irq_ok` are 1 only while the bus is active and the state is D0.
- R5: `cfg_resp_ok` is 1 in the cycle after `cfg_strobe` is sampled high with the bus active, in every state.
- R6: In D1, D2 or D3 with wake enabled, two events set the pending status at the next edge: `wake_pkt` sampled high, or a change of the synchronised link. `pme_n` is then 0. A change of `link_valid` first sampled at edge k sets the status at edge k+2.
- R7: In D0 no event sets the pending status.
- R8: `pme_n` stays 0 until `pme_clr` is sampled high with the bus active, or until the registered wake enable is 0. A wake event in the same cycle as a clear wins.
- R9: `low_power` is 1 in D2 or D3 when the low-power enable is set and the synchronised link is down. A later link return is a wake event. In D0 and D1 `low_power` is 0 in the same cycle the state changes.
- R10: In D3 with wake disabled, no event is reported and `low_power` is 1 whatever the link does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| aux_rst_n | input | 1 | Auxiliary-well reset, active low |
| bus_rst_n | input | 1 | Bus reset, active low |
| pwr_good | input | 1 | Bus power good |
| req_dstate | input | 2 | Requested power state |
| pme_en | input | 1 | Wake enable from configuration |
| lp_en | input | 1 | Low-power-on-link-down enable |
| cfg_strobe | input | 1 | Configuration access strobe |
| pme_clr | input | 1 | Write-one-to-clear of pending wake |
| link_valid | input | 1 | Asynchronous link-valid indication |
| wake_pkt | input | 1 | Wake-packet match pulse |
| bus_master_ok | output | 1 | Bus mastering allowed |
| irq_ok | output | 1 | Interrupts allowed |
| cfg_resp_ok | output | 1 | Configuration access answered |
| low_power | output | 1 | Low-power sub-mode active |
| pme_n | output | 1 | Wake signal, active low |

## Verification
Two collisions matter here. In the first, a wake event and the software clear of the pending status land in the same cycle. The bench provokes it by pulsing `wake_pkt` and `pme_clr` together while a wake is already pending, and expects `pme_n` to stay low. In the second, a wake event arrives during a bus reset. It must be recorded, and the pending status must survive the release that returns the state to D0. A behavioural reference model compares all outputs every cycle through directed phases and a long random phase.

// File: rtl/nic_pmw_pkg.sv
package nic_pmw_pkg;
   typedef enum logic [1:0] {
      PWR_D0 = 2'd0,
      PWR_D1 = 2'd1,
      PWR_D2 = 2'd2,
      PWR_D3 = 2'd3
   } pwr_state_e;

   function automatic logic is_asleep(pwr_state_e s);
      return s != PWR_D0;
   endfunction

   function automatic logic is_deep(pwr_state_e s);
      return (s == PWR_D2) || (s == PWR_D3);
   endfunction
endpackage

// File: rtl/nic_pmw_link_sync.sv
module nic_pmw_link_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic din,
   output logic dout,
   output logic toggled
);
   localparam int TOP = STAGES - 1;

   if (STAGES < 2) begin : g_bad_stages
      initial $error("nic_pmw_link_sync: STAGES must be at least 2");
   end

   logic [TOP:0] chain;
   logic         last;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         chain <= '0;
         last  <= 1'b0;
      end else begin
         chain <= {chain[TOP-1:0], din};
         last  <= chain[TOP];
      end
   end

   assign dout    = chain[TOP];
   assign toggled = chain[TOP] ^ last;
endmodule

// File: rtl/nic_pmw_func_state.sv
module nic_pmw_func_state
   import nic_pmw_pkg::*;
#(
   parameter int STATE_W = 2
) (
   input  logic               clk,
   input  logic               aux_rst_n,
   input  logic               bus_active,
   input  logic [STATE_W-1:0] req_dstate,
   input  logic               pme_en_in,
   input  logic               lp_en_in,
   output pwr_state_e         dstate,
   output logic               pme_en_q,
   output logic               lp_en_q
);
   if (STATE_W != $bits(pwr_state_e)) begin : g_bad_width
      initial $error("nic_pmw_func_state: STATE_W must match the state type");
   end

   logic was_active;

   always_ff @(posedge clk or negedge aux_rst_n) begin
      if (!aux_rst_n) begin
         was_active <= 1'b0;
         dstate     <= PWR_D0;
         pme_en_q   <= 1'b0;
         lp_en_q    <= 1'b0;
      end else begin
         was_active <= bus_active;
         if (bus_active) begin
            pme_en_q <= pme_en_in;
            lp_en_q  <= lp_en_in;
            dstate   <= was_active ? pwr_state_e'(req_dstate) : PWR_D0;
         end
      end
   end
endmodule

// File: rtl/nic_pmw_wake.sv
module nic_pmw_wake
   import nic_pmw_pkg::*;
#(
   parameter bit LINK_WAKE_EN = 1'b1
) (
   input  logic       clk,
   input  logic       aux_rst_n,
   input  logic       bus_active,
   input  pwr_state_e dstate,
   input  logic       pme_en_q,
   input  logic       lp_en_q,
   input  logic       link_s,
   input  logic       link_chg,
   input  logic       wake_pkt,
   input  logic       pme_clr,
   output logic       pme_n,
   output logic       low_power
);
   logic link_ev;
   logic wake_set;
   logic pend;

   if (LINK_WAKE_EN) begin : g_link_wake
      assign link_ev = link_chg;
   end else begin : g_no_link_wake
      assign link_ev = 1'b0;
   end

   assign wake_set = pme_en_q & is_asleep(dstate) & (wake_pkt | link_ev);

   always_ff @(posedge clk or negedge aux_rst_n) begin
      if (!aux_rst_n) begin
         pend <= 1'b0;
      end else if (!pme_en_q) begin
         pend <= 1'b0;
      end else if (wake_set) begin
         pend <= 1'b1;
      end else if (bus_active && pme_clr) begin
         pend <= 1'b0;
      end
   end

   assign pme_n     = ~(pend & pme_en_q);
   assign low_power = (is_deep(dstate) & lp_en_q & ~link_s)
                    | ((dstate == PWR_D3) & ~pme_en_q);
endmodule

// File: rtl/nic_pm_wake_mgr.sv
module nic_pm_wake_mgr
   import nic_pmw_pkg::*;
#(
   parameter int SYNC_STAGES  = 2,
   parameter bit LINK_WAKE_EN = 1'b1
) (
   input  logic       clk,
   input  logic       aux_rst_n,
   input  logic       bus_rst_n,
   input  logic       pwr_good,
   input  logic [1:0] req_dstate,
   input  logic       pme_en,
   input  logic       lp_en,
   input  logic       cfg_strobe,
   input  logic       pme_clr,
   input  logic       link_valid,
   input  logic       wake_pkt,
   output logic       bus_master_ok,
   output logic       irq_ok,
   output logic       cfg_resp_ok,
   output logic       low_power,
   output logic       pme_n
);
   localparam int STATE_W = $bits(pwr_state_e);

   logic       bus_active;
   pwr_state_e dstate;
   logic       pme_en_q;
   logic       lp_en_q;
   logic       link_s;
   logic       link_chg;
   logic       cfg_q;

   assign bus_active = bus_rst_n & pwr_good;

   nic_pmw_link_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk    (clk),
      .rst_n  (aux_rst_n),
      .din    (link_valid),
      .dout   (link_s),
      .toggled(link_chg)
   );

   nic_pmw_func_state #(.STATE_W(STATE_W)) u_state (
      .clk       (clk),
      .aux_rst_n (aux_rst_n),
      .bus_active(bus_active),
      .req_dstate(req_dstate),
      .pme_en_in (pme_en),
      .lp_en_in  (lp_en),
      .dstate    (dstate),
      .pme_en_q  (pme_en_q),
      .lp_en_q   (lp_en_q)
   );

   nic_pmw_wake #(.LINK_WAKE_EN(LINK_WAKE_EN)) u_wake (
      .clk       (clk),
      .aux_rst_n (aux_rst_n),
      .bus_active(bus_active),
      .dstate    (dstate),
      .pme_en_q  (pme_en_q),
      .lp_en_q   (lp_en_q),
      .link_s    (link_s),
      .link_chg  (link_chg),
      .wake_pkt  (wake_pkt),
      .pme_clr   (pme_clr),
      .pme_n     (pme_n),
      .low_power (low_power)
   );

   always_ff @(posedge clk or negedge aux_rst_n) begin
      if (!aux_rst_n) cfg_q <= 1'b0;
      else            cfg_q <= bus_active & cfg_strobe;
   end

   assign cfg_resp_ok   = cfg_q;
   assign bus_master_ok = bus_active & (dstate == PWR_D0);
   assign irq_ok        = bus_active & (dstate == PWR_D0);
endmodule

// File: rtl/nic_pmw_chk.sv
module nic_pmw_chk
   import nic_pmw_pkg::*;
(
   input logic       clk,
   input logic       aux_rst_n,
   input logic       bus_rst_n,
   input logic       pwr_good,
   input logic       pme_en,
   input logic       cfg_strobe,
   input logic       pme_clr,
   input logic       bus_master_ok,
   input logic       cfg_resp_ok,
   input logic       low_power,
   input logic       pme_n,
   input pwr_state_e dstate,
   input logic       pme_en_q,
   input logic       lp_en_q
);
   AST_CFG_BLOCKED_IN_RESET: assert property (@(posedge clk) disable iff (!aux_rst_n)
      !bus_rst_n |=> !cfg_resp_ok) else $error("cfg answered in bus reset"); // R2

   AST_ENABLES_KEPT: assert property (@(posedge clk) disable iff (!aux_rst_n)
      (!bus_rst_n || !pwr_good) |=> ($stable(pme_en_q) && $stable(lp_en_q)))
      else $error("enables lost in bus reset"); // R3

   AST_MASTER_ONLY_D0: assert property (@(posedge clk) disable iff (!aux_rst_n)
      bus_master_ok |-> (dstate == PWR_D0)) else $error("master outside D0"); // R4

   AST_CFG_ANSWERED: assert property (@(posedge clk) disable iff (!aux_rst_n)
      (bus_rst_n && pwr_good && cfg_strobe) |=> cfg_resp_ok)
      else $error("cfg strobe not answered"); // R5

   AST_WAKE_NEEDS_SLEEP: assert property (@(posedge clk) disable iff (!aux_rst_n)
      $fell(pme_n) |-> ($past(pme_en_q) && ($past(dstate) != PWR_D0)))
      else $error("wake asserted without cause"); // R6

   AST_D0_QUIET: assert property (@(posedge clk) disable iff (!aux_rst_n)
      ((dstate == PWR_D0) && pme_n) |=> pme_n) else $error("wake set in D0"); // R7

   AST_WAKE_HOLD: assert property (@(posedge clk) disable iff (!aux_rst_n)
      (!pme_n && !pme_clr && (!(bus_rst_n && pwr_good) || pme_en)) |=> !pme_n)
      else $error("wake dropped without clear"); // R8

   AST_LP_SHALLOW: assert property (@(posedge clk) disable iff (!aux_rst_n)
      ((dstate == PWR_D0) || (dstate == PWR_D1)) |-> !low_power)
      else $error("low power in shallow state"); // R9
endmodule

bind nic_pm_wake_mgr nic_pmw_chk u_chk (
   .clk          (clk),
   .aux_rst_n    (aux_rst_n),
   .bus_rst_n    (bus_rst_n),
   .pwr_good     (pwr_good),
   .pme_en       (pme_en),
   .cfg_strobe   (cfg_strobe),
   .pme_clr      (pme_clr),
   .bus_master_ok(bus_master_ok),
   .cfg_resp_ok  (cfg_resp_ok),
   .low_power    (low_power),
   .pme_n        (pme_n),
   .dstate       (dstate),
   .pme_en_q     (pme_en_q),
   .lp_en_q      (lp_en_q)
);

// File: tb/nic_pm_wake_mgr_tb_top.sv
module nic_pm_wake_mgr_tb_top;
   localparam int CLK_PERIOD = 10;
   localparam int SYNC       = 2;

   logic       clk = 1'b0;
   logic       aux_rst_n = 1'b0, bus_rst_n = 1'b0, pwr_good = 1'b0;
   logic [1:0] req_dstate = 2'd0;
   logic       pme_en = 1'b0, lp_en = 1'b0, cfg_strobe = 1'b0, pme_clr = 1'b0;
   logic       link_valid = 1'b0, wake_pkt = 1'b0;
   logic       bus_master_ok, irq_ok, cfg_resp_ok, low_power, pme_n;

   int    n_chk = 0;
   int    n_fail = 0;
   string cur_req = "R1";
   bit    finished = 1'b0;

   // reference model state
   int m_d = 0;
   bit m_en = 0, m_lp = 0, m_sts = 0, m_cfg = 0, m_actp = 0;
   bit lq[$];

   always #(CLK_PERIOD/2) clk = ~clk;

   nic_pm_wake_mgr dut_i (
      .clk(clk), .aux_rst_n(aux_rst_n), .bus_rst_n(bus_rst_n), .pwr_good(pwr_good),
      .req_dstate(req_dstate), .pme_en(pme_en), .lp_en(lp_en), .cfg_strobe(cfg_strobe),
      .pme_clr(pme_clr), .link_valid(link_valid), .wake_pkt(wake_pkt),
      .bus_master_ok(bus_master_ok), .irq_ok(irq_ok), .cfg_resp_ok(cfg_resp_ok),
      .low_power(low_power), .pme_n(pme_n)
   );

   initial lq = '{1'b0, 1'b0, 1'b0};

   always @(posedge clk) begin
      bit act, chg, ev;
      if (!aux_rst_n) begin
         m_d = 0; m_en = 0; m_lp = 0; m_sts = 0; m_cfg = 0; m_actp = 0;
         lq = '{1'b0, 1'b0, 1'b0};
      end else begin
         act = bus_rst_n && pwr_good;
         chg = lq[lq.size()-SYNC] != lq[lq.size()-SYNC-1];
         ev  = m_en && (m_d != 0) && (wake_pkt || chg);
         if (!m_en)              m_sts = 0;
         else if (ev)            m_sts = 1;
         else if (act && pme_clr) m_sts = 0;
         m_cfg = act && cfg_strobe;
         if (act) begin
            m_d  = m_actp ? int'(req_dstate) : 0;
            m_en = pme_en;
            m_lp = lp_en;
         end
         m_actp = act;
         lq.push_back(link_valid);
         void'(lq.pop_front());
      end
   end

   function automatic void chk1(string nm, logic act, logic exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s actual=%0b expected=%0b t=%0t", cur_req, nm, act, exp, $time);
      end
   endfunction

   task automatic compare();
      bit a;
      bit linkd;
      a     = bus_rst_n && pwr_good;
      linkd = !lq[lq.size()-SYNC];
      chk1("bus_master_ok", bus_master_ok, a && (m_d == 0));
      chk1("irq_ok", irq_ok, a && (m_d == 0));
      chk1("cfg_resp_ok", cfg_resp_ok, m_cfg);
      chk1("low_power", low_power, ((m_d >= 2) && m_lp && linkd) || ((m_d == 3) && !m_en));
      chk1("pme_n", pme_n, !(m_sts && m_en));
   endtask

   task automatic cyc(int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         compare();
      end
   endtask

   task automatic wake_pulse();
      wake_pkt = 1'b1; cyc(1); wake_pkt = 1'b0; cyc(1);
   endtask

   task automatic clear_pulse();
      pme_clr = 1'b1; cyc(1); pme_clr = 1'b0; cyc(1);
   endtask

   initial begin
      repeat (CLK_PERIOD * 10000) @(posedge clk);
      if (!finished) begin
         n_chk++; n_fail++;
         $display("FAIL %s watchdog actual=running expected=done", cur_req);
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   initial begin
      // R1: auxiliary reset state
      cur_req = "R1";
      repeat (3) @(negedge clk);
      compare();
      chk1("pme_n reset", pme_n, 1'b1);
      chk1("low_power reset", low_power, 1'b0);
      chk1("cfg_resp_ok reset", cfg_resp_ok, 1'b0);
      aux_rst_n = 1'b1; pwr_good = 1'b1; bus_rst_n = 1'b1;
      cyc(3);

      // R4: D0 allows mastering and interrupts
      cur_req = "R4";
      chk1("bus_master_ok D0", bus_master_ok, 1'b1);
      chk1("irq_ok D0", irq_ok, 1'b1);

      // R5: configuration response
      cur_req = "R5";
      cfg_strobe = 1'b1; cyc(1); cfg_strobe = 1'b0;
      chk1("cfg_resp_ok after strobe", cfg_resp_ok, 1'b1);
      cyc(2);

      // R7: events in D0 are not recorded
      cur_req = "R7";
      pme_en = 1'b1; cyc(2);
      wake_pulse();
      link_valid = 1'b1; cyc(5);
      chk1("pme_n D0 quiet", pme_n, 1'b1);

      // R6: D1 wake packet and link change
      cur_req = "R6";
      req_dstate = 2'd1; cyc(2);
      chk1("bus_master_ok D1", bus_master_ok, 1'b0);
      cfg_strobe = 1'b1; cyc(1); cfg_strobe = 1'b0;
      chk1("cfg_resp_ok D1", cfg_resp_ok, 1'b1);
      wake_pkt = 1'b1; cyc(1); wake_pkt = 1'b0;
      chk1("pme_n after packet", pme_n, 1'b0);
      clear_pulse();
      chk1("pme_n after clear", pme_n, 1'b1);
      link_valid = 1'b0; cyc(2);
      chk1("pme_n link latency", pme_n, 1'b1);
      cyc(1);
      chk1("pme_n link change", pme_n, 1'b0);

      // R8: collision of event and clear, then enable drop
      cur_req = "R8";
      cyc(2);
      wake_pkt = 1'b1; pme_clr = 1'b1; cyc(1);
      wake_pkt = 1'b0; pme_clr = 1'b0;
      chk1("pme_n event beats clear", pme_n, 1'b0);
      cyc(3);
      chk1("pme_n held", pme_n, 1'b0);
      pme_en = 1'b0; cyc(1);
      chk1("pme_n enable dropped", pme_n, 1'b1);
      pme_en = 1'b1; cyc(2);
      chk1("pme_n stays clear", pme_n, 1'b1);

      // R9: D2 low-power sub-mode and link return wake
      cur_req = "R9";
      lp_en = 1'b1; req_dstate = 2'd2; cyc(4);
      chk1("low_power D2 link down", low_power, 1'b1);
      link_valid = 1'b1; cyc(4);
      chk1("pme_n link return", pme_n, 1'b0);
      chk1("low_power link up", low_power, 1'b0);
      clear_pulse();
      link_valid = 1'b0; cyc(4);
      clear_pulse();
      req_dstate = 2'd0; cyc(1);
      chk1("low_power leaves D0 at once", low_power, 1'b0);
      cyc(2);

      // R10: D3 with wake disabled
      cur_req = "R10";
      pme_en = 1'b0; req_dstate = 2'd3; cyc(2);
      link_valid = 1'b1; cyc(4);
      wake_pulse();
      chk1("pme_n D3 disabled", pme_n, 1'b1);
      chk1("low_power D3 disabled", low_power, 1'b1);

      // R2 and R3: bus reset with a pending wake
      cur_req = "R3";
      pme_en = 1'b1; cyc(2);
      wake_pulse();
      chk1("pme_n before reset", pme_n, 1'b0);
      cur_req = "R2";
      bus_rst_n = 1'b0;
      pme_en = 1'b0; lp_en = 1'b0; pme_clr = 1'b1; cfg_strobe = 1'b1; req_dstate = 2'd0;
      cyc(4);
      chk1("cfg_resp_ok in reset", cfg_resp_ok, 1'b0);
      chk1("bus_master_ok in reset", bus_master_ok, 1'b0);
      chk1("pme_n kept in reset", pme_n, 1'b0);
      pme_clr = 1'b0; cfg_strobe = 1'b0;
      pwr_good = 1'b0; wake_pulse(); cyc(2);
      cur_req = "R3";
      pme_en = 1'b1; lp_en = 1'b1; req_dstate = 2'd3;
      pwr_good = 1'b1; bus_rst_n = 1'b1; cyc(1);
      chk1("bus_master_ok first active cycle", bus_master_ok, 1'b1);
      chk1("pme_n survives release", pme_n, 1'b0);
      cyc(1);
      chk1("bus_master_ok follows request", bus_master_ok, 1'b0);
      clear_pulse();

      // R6: random stress against the model
      cur_req = "R6";
      for (int i = 0; i < 3000; i++) begin
         req_dstate = 2'($urandom_range(0, 3));
         pme_en     = ($urandom_range(0, 7) != 0);
         lp_en      = 1'($urandom_range(0, 1));
         cfg_strobe = 1'($urandom_range(0, 1));
         pme_clr    = ($urandom_range(0, 5) == 0);
         wake_pkt   = ($urandom_range(0, 9) == 0);
         link_valid = ($urandom_range(0, 7) == 0) ? ~link_valid : link_valid;
         bus_rst_n  = ($urandom_range(0, 19) != 0);
         pwr_good   = ($urandom_range(0, 29) != 0);
         cyc(1);
      end

      finished = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule